// File: doc/BRIEF.md
# CPU Interrupt Control Unit

This block decides, for an 8-bit processor core, when an interrupt is taken and where execution goes next. It keeps two interrupt-enable bits: a live enable that gates the maskable request, and a shadow copy that holds the live value while a non-maskable routine runs. It also keeps a three-way response mode and an 8-bit page register. The instruction decoder drives it with one-cycle strobes for enable, disable, mode select, return-from-non-maskable, return-from-maskable and page load. The sequencer drives a strobe at each instruction boundary.

At a boundary strobe the unit takes a latched non-maskable event first. If there is none, it takes a maskable request when that request is low and the live enable is set. The cycle after the decision, it shows a one-cycle take pulse, the target address and a kind code. The kind code tells the sequencer whether the address is a jump target, a pointer into a vector table, or an opcode byte that the core must execute. Separate one-cycle pulses acknowledge a maskable acceptance and announce a return-from-maskable, so that chained peripherals can clear their pending state.

Top module: `intc_top`

## Requirements
- R1: While reset is asserted and after it is released, both enables are 0, the mode is 0 and the page register is 00h. No take, acknowledge or return pulse is shown.
- R2: A falling edge on `nmi_n` is latched until it is taken at a boundary strobe. On the take, the shadow enable gets the live enable value and the live enable clears, in the same step. The cycle after the take, `take` and `take_nmi` are 1, `tgt_addr` is 0066h and `tgt_kind` is 0 (jump).
- R3: `ret_nmi_stb` copies the shadow enable into the live enable on the next edge.
- R4: A maskable request (`irq_n` low) is taken only at a boundary strobe and only while the live enable is 1. Taking it clears both enables. They stay clear until `en_stb`.
- R5: In mode 1 a maskable take gives `tgt_addr` = 0038h and `tgt_kind` = 0.
- R6: In mode 2 a maskable take gives `tgt_addr` = {page, dev_byte} and `tgt_kind` = 1 (table pointer).
- R7: In mode 0 a device byte of the form 11nnn111 gives `tgt_addr` = nnn×8 and `tgt_kind` = 0. Any other byte gives `tgt_addr` = {00h, dev_byte} and `tgt_kind` = 2 (opcode to execute).
- R8: A pending non-maskable event wins over a maskable request at the same boundary. It is taken whatever the enable values are. A second non-maskable take overwrites the shadow enable.
- R9: `ret_irq_stb` produces a one-cycle `reti_pulse` on the next cycle.
- R10: `ack` is a one-cycle pulse that comes with each maskable take and never with a non-maskable take.
- R11: `mode_stb` loads `mode_sel` when `mode_sel` is 0, 1 or 2. A value of 3 leaves the mode unchanged. `page_ld` loads `page_data` into the page register.
- R12: `dis_stb` clears both enables and `en_stb` sets both. A take at the same edge has priority over either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 1 | Maskable request, level, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| dev_byte | input | 8 | Byte supplied by the interrupting device |
| boundary | input | 1 | Instruction boundary strobe |
| en_stb | input | 1 | Enable-interrupts strobe |
| dis_stb | input | 1 | Disable-interrupts strobe |
| mode_stb | input | 1 | Mode select strobe |
| mode_sel | input | 2 | Requested mode |
| ret_nmi_stb | input | 1 | Return-from-non-maskable strobe |
| ret_irq_stb | input | 1 | Return-from-maskable strobe |
| page_ld | input | 1 | Page register load strobe |
| page_data | input | 8 | Value for the page register |
| take | output | 1 | One-cycle pulse: an interrupt was taken |
| take_nmi | output | 1 | The take was non-maskable |
| ack | output | 1 | Maskable acknowledge pulse |
| tgt_addr | output | 16 | Target address or table pointer |
| tgt_kind | output | 2 | 0 jump, 1 table pointer, 2 opcode byte |
| reti_pulse | output | 1 | Return-from-maskable pulse |
| en_main | output | 1 | Live enable |
| en_shadow | output | 1 | Shadow enable |
| mode | output | 2 | Current response mode |
| page | output | 8 | Page register |

## Verification
The assertions check, on every cycle, the rules that follow from the previous cycle alone. These are: the enable save and clear on each take, the shadow-to-live copy on return, the gating of maskable takes by the live enable, the fixed and table-pointer targets, the precedence of a pending non-maskable event, and the pairing of `ack` with maskable takes only. Other behaviour shows only in the bench's scenarios: the restart decode over many device bytes, the non-maskable event staying latched across the synchronizer and while waiting for a boundary, a second non-maskable take that loses the saved enable, the rejected mode value, and the enables staying clear after an acceptance until an enable strobe.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [1:0] {
    MODE_OPC   = 2'd0,
    MODE_FIXED = 2'd1,
    MODE_TABLE = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    KIND_JUMP   = 2'd0,
    KIND_TABLE  = 2'd1,
    KIND_OPCODE = 2'd2
  } kind_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    kind_e         kind;
  } target_t;

  localparam logic [AW-1:0] NMI_TARGET   = AW'(16'h0066);
  localparam logic [AW-1:0] FIXED_TARGET = AW'(16'h0038);

  // single-byte restart opcode: top two bits and bottom three bits all ones
  function automatic logic is_restart(input logic [DW-1:0] op);
    return (op[DW-1:DW-2] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

  // restart slot number times eight
  function automatic logic [AW-1:0] restart_target(input logic [DW-1:0] op);
    return AW'({op[5:3], 3'b000});
  endfunction

  function automatic logic [AW-1:0] table_ptr(input logic [DW-1:0] pg,
                                              input logic [DW-1:0] dv);
    return {pg, dv};
  endfunction
endpackage

// File: rtl/intc_nmi_latch.sv
module intc_nmi_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic taken,
  output logic fall,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b1;
        else        sync_q <= nmi_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_n};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  // a new edge arriving with a take stays pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= fall | (pend & ~taken);
  end
endmodule

// File: rtl/intc_enables.sv
module intc_enables
  import intc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_nmi,
  input  logic          acc_irq,
  input  logic          en_stb,
  input  logic          dis_stb,
  input  logic          ret_nmi_stb,
  input  logic          mode_stb,
  input  logic [1:0]    mode_sel,
  input  logic          page_ld,
  input  logic [DW-1:0] page_data,
  output logic          en_main,
  output logic          en_shadow,
  output mode_e         mode,
  output logic [DW-1:0] page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_main   <= 1'b0;
      en_shadow <= 1'b0;
    end else if (acc_nmi) begin
      en_shadow <= en_main;
      en_main   <= 1'b0;
    end else if (acc_irq) begin
      en_main   <= 1'b0;
      en_shadow <= 1'b0;
    end else if (ret_nmi_stb) begin
      en_main   <= en_shadow;
    end else if (dis_stb) begin
      en_main   <= 1'b0;
      en_shadow <= 1'b0;
    end else if (en_stb) begin
      en_main   <= 1'b1;
      en_shadow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mode <= MODE_OPC;
    else if (mode_stb && mode_sel != 2'b11) mode <= mode_e'(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page <= '0;
    else if (page_ld) page <= page_data;
  end
endmodule

// File: rtl/intc_vector.sv
module intc_vector
  import intc_pkg::*;
(
  input  logic          is_nmi,
  input  mode_e         mode,
  input  logic [DW-1:0] page,
  input  logic [DW-1:0] dev_byte,
  output target_t       tgt
);
  always_comb begin
    tgt.addr = '0;
    tgt.kind = KIND_JUMP;
    if (is_nmi) begin
      tgt.addr = NMI_TARGET;
    end else begin
      unique case (mode)
        MODE_FIXED: tgt.addr = FIXED_TARGET;
        MODE_TABLE: begin
          tgt.addr = table_ptr(page, dev_byte);
          tgt.kind = KIND_TABLE;
        end
        default: begin
          if (is_restart(dev_byte)) begin
            tgt.addr = restart_target(dev_byte);
          end else begin
            tgt.addr = AW'(dev_byte);
            tgt.kind = KIND_OPCODE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_n,
  input  logic          nmi_n,
  input  logic [7:0]    dev_byte,
  input  logic          boundary,
  input  logic          en_stb,
  input  logic          dis_stb,
  input  logic          mode_stb,
  input  logic [1:0]    mode_sel,
  input  logic          ret_nmi_stb,
  input  logic          ret_irq_stb,
  input  logic          page_ld,
  input  logic [7:0]    page_data,
  output logic          take,
  output logic          take_nmi,
  output logic          ack,
  output logic [15:0]   tgt_addr,
  output logic [1:0]    tgt_kind,
  output logic          reti_pulse,
  output logic          en_main,
  output logic          en_shadow,
  output logic [1:0]    mode,
  output logic [7:0]    page
);
  logic    nmi_fall;
  logic    nmi_pend;
  logic    nmi_take;
  logic    irq_take;
  mode_e   mode_q;
  target_t tgt_next;

  assign nmi_take = boundary & nmi_pend;
  assign irq_take = boundary & ~nmi_pend & en_main & ~irq_n;

  intc_nmi_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .nmi_n (nmi_n),
    .taken (nmi_take),
    .fall  (nmi_fall),
    .pend  (nmi_pend)
  );

  intc_enables u_en (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_nmi     (nmi_take),
    .acc_irq     (irq_take),
    .en_stb      (en_stb),
    .dis_stb     (dis_stb),
    .ret_nmi_stb (ret_nmi_stb),
    .mode_stb    (mode_stb),
    .mode_sel    (mode_sel),
    .page_ld     (page_ld),
    .page_data   (page_data),
    .en_main     (en_main),
    .en_shadow   (en_shadow),
    .mode        (mode_q),
    .page        (page)
  );

  intc_vector u_vec (
    .is_nmi   (nmi_pend),
    .mode     (mode_q),
    .page     (page),
    .dev_byte (dev_byte),
    .tgt      (tgt_next)
  );

  assign mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take       <= 1'b0;
      take_nmi   <= 1'b0;
      ack        <= 1'b0;
      tgt_addr   <= '0;
      tgt_kind   <= KIND_JUMP;
      reti_pulse <= 1'b0;
    end else begin
      take       <= nmi_take | irq_take;
      take_nmi   <= nmi_take;
      ack        <= irq_take;
      reti_pulse <= ret_irq_stb;
      if (nmi_take | irq_take) begin
        tgt_addr <= tgt_next.addr;
        tgt_kind <= tgt_next.kind;
      end
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        nmi_pend,
  input logic        nmi_take,
  input logic        irq_take,
  input logic        take,
  input logic        take_nmi,
  input logic        ack,
  input logic [15:0] tgt_addr,
  input logic [1:0]  tgt_kind,
  input logic        en_main,
  input logic        en_shadow,
  input logic [1:0]  mode,
  input logic [7:0]  page,
  input logic [7:0]  dev_byte,
  input logic        ret_nmi_stb,
  input logic        ret_irq_stb,
  input logic        reti_pulse
);
  assert_nmi_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> (tgt_addr == 16'h0066 && tgt_kind == 2'd0 && !en_main));

  assert_nmi_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> (en_shadow == $past(en_main)));

  assert_ret_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_nmi_stb && !boundary) |=> (en_main == $past(en_shadow)));

  assert_irq_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (!en_main && !en_shadow && ack));

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !en_main && !nmi_pend) |=> !take);

  assert_fixed_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_nmi && $past(mode) == 2'd1) |-> (tgt_addr == 16'h0038 && tgt_kind == 2'd0));

  assert_table_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_nmi && $past(mode) == 2'd2) |->
      (tgt_addr == {$past(page), $past(dev_byte)} && tgt_kind == 2'd1));

  assert_nmi_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && nmi_pend) |=> (take_nmi && !ack));

  assert_reti_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_irq_stb |=> reti_pulse);

  assert_ack_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack, take_nmi}) && ((ack || take_nmi) == take));

  assert_take_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_take && irq_take));
endmodule

bind intc_top intc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .boundary    (boundary),
  .nmi_pend    (nmi_pend),
  .nmi_take    (nmi_take),
  .irq_take    (irq_take),
  .take        (take),
  .take_nmi    (take_nmi),
  .ack         (ack),
  .tgt_addr    (tgt_addr),
  .tgt_kind    (tgt_kind),
  .en_main     (en_main),
  .en_shadow   (en_shadow),
  .mode        (mode),
  .page        (page),
  .dev_byte    (dev_byte),
  .ret_nmi_stb (ret_nmi_stb),
  .ret_irq_stb (ret_irq_stb),
  .reti_pulse  (reti_pulse)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {mode[1:0], page[7:0], dev[7:0], exp_addr[15:0], exp_kind[1:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {2'd1, 8'h00, 8'h5A, 16'h0038, 2'd0},
    {2'd1, 8'h7F, 8'hFF, 16'h0038, 2'd0},
    {2'd2, 8'h12, 8'h34, 16'h1234, 2'd1},
    {2'd2, 8'hFF, 8'hFE, 16'hFFFE, 2'd1},
    {2'd2, 8'hA5, 8'h00, 16'hA500, 2'd1},
    {2'd0, 8'h00, 8'hC7, 16'h0000, 2'd0},
    {2'd0, 8'h00, 8'hCF, 16'h0008, 2'd0},
    {2'd0, 8'h00, 8'hD7, 16'h0010, 2'd0},
    {2'd0, 8'h00, 8'hFF, 16'h0038, 2'd0},
    {2'd0, 8'h00, 8'hCD, 16'h00CD, 2'd2},
    {2'd0, 8'h00, 8'h00, 16'h0000, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_n = 1'b1, nmi_n = 1'b1;
  logic [7:0] dev_byte = '0;
  logic boundary = 1'b0, en_stb = 1'b0, dis_stb = 1'b0, mode_stb = 1'b0;
  logic [1:0] mode_sel = '0;
  logic ret_nmi_stb = 1'b0, ret_irq_stb = 1'b0, page_ld = 1'b0;
  logic [7:0] page_data = '0;
  logic take, take_nmi, ack, reti_pulse, en_main, en_shadow;
  logic [15:0] tgt_addr;
  logic [1:0] tgt_kind, mode;
  logic [7:0] page;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n), .dev_byte(dev_byte),
    .boundary(boundary), .en_stb(en_stb), .dis_stb(dis_stb), .mode_stb(mode_stb),
    .mode_sel(mode_sel), .ret_nmi_stb(ret_nmi_stb), .ret_irq_stb(ret_irq_stb),
    .page_ld(page_ld), .page_data(page_data), .take(take), .take_nmi(take_nmi),
    .ack(ack), .tgt_addr(tgt_addr), .tgt_kind(tgt_kind), .reti_pulse(reti_pulse),
    .en_main(en_main), .en_shadow(en_shadow), .mode(mode), .page(page)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_boundary();
    boundary = 1'b1; step(); boundary = 1'b0;
  endtask

  task automatic do_en();  en_stb = 1'b1;  step(); en_stb = 1'b0;  endtask
  task automatic do_dis(); dis_stb = 1'b1; step(); dis_stb = 1'b0; endtask
  task automatic do_ret_nmi(); ret_nmi_stb = 1'b1; step(); ret_nmi_stb = 1'b0; endtask

  task automatic set_mode(input logic [1:0] m);
    mode_sel = m; mode_stb = 1'b1; step(); mode_stb = 1'b0;
  endtask

  task automatic load_page(input logic [7:0] p);
    page_data = p; page_ld = 1'b1; step(); page_ld = 1'b0;
  endtask

  task automatic fire_nmi();
    nmi_n = 1'b0;
    repeat (4) step();
    check("R2 no take before boundary", {31'd0, take}, 32'd0);
    nmi_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state, held in reset
    check("R1 en_main", {31'd0, en_main}, 32'd0);
    check("R1 mode", {30'd0, mode}, 32'd0);
    rst_n = 1'b1;
    step();
    check("R1 en_shadow", {31'd0, en_shadow}, 32'd0);
    check("R1 page", {24'd0, page}, 32'd0);
    check("R1 take", {31'd0, take}, 32'd0);

    // vector table: maskable takes in each mode (R5 R6 R7 R10 R4)
    foreach (VEC[i]) begin
      set_mode(VEC[i][35:34]);
      load_page(VEC[i][33:26]);
      do_en();
      dev_byte = VEC[i][25:18];
      irq_n = 1'b0;
      pulse_boundary();
      irq_n = 1'b1;
      check("R5/R6/R7 take", {31'd0, take}, 32'd1);
      check("R5/R6/R7 tgt_addr", {16'd0, tgt_addr}, {16'd0, VEC[i][17:2]});
      check("R5/R6/R7 tgt_kind", {30'd0, tgt_kind}, {30'd0, VEC[i][1:0]});
      check("R10 ack", {31'd0, ack}, 32'd1);
      check("R4 enables cleared", {30'd0, en_main, en_shadow}, 32'd0);
      step();
      check("R10 ack one cycle", {31'd0, ack}, 32'd0);
    end

    // R4 stays clear after acceptance, no new take
    irq_n = 1'b0;
    pulse_boundary();
    check("R4 disabled ignores request", {31'd0, take}, 32'd0);
    // R12 enable / disable strobes
    do_en();
    check("R12 enable sets both", {30'd0, en_main, en_shadow}, 32'd3);
    step();
    check("R4 no take without boundary", {31'd0, take}, 32'd0);
    do_dis();
    check("R12 disable clears both", {30'd0, en_main, en_shadow}, 32'd0);
    pulse_boundary();
    check("R4 request ignored after disable", {31'd0, take}, 32'd0);
    irq_n = 1'b1;

    // R2 non-maskable entry saves live enable
    do_en();
    fire_nmi();
    pulse_boundary();
    check("R2 take_nmi", {30'd0, take, take_nmi}, 32'd3);
    check("R2 target", {16'd0, tgt_addr}, 32'h0066);
    check("R2 kind", {30'd0, tgt_kind}, 32'd0);
    check("R2 enables saved", {30'd0, en_main, en_shadow}, 32'd1);
    check("R10 no ack on nmi", {31'd0, ack}, 32'd0);
    // R3 restore
    do_ret_nmi();
    check("R3 live restored", {31'd0, en_main}, 32'd1);

    // R8 priority over a maskable request at the same boundary
    irq_n = 1'b0;
    fire_nmi();
    pulse_boundary();
    check("R8 nmi wins", {30'd0, take_nmi, ack}, 32'd2);
    check("R8 shadow holds 1", {31'd0, en_shadow}, 32'd1);
    irq_n = 1'b1;
    // second nmi while live enable clear overwrites shadow
    fire_nmi();
    pulse_boundary();
    check("R8 second nmi taken", {31'd0, take_nmi}, 32'd1);
    check("R8 shadow overwritten", {31'd0, en_shadow}, 32'd0);
    do_ret_nmi();
    check("R8 restore gives 0", {31'd0, en_main}, 32'd0);

    // R9 return-from-maskable pulse
    ret_irq_stb = 1'b1; step(); ret_irq_stb = 1'b0;
    check("R9 pulse", {31'd0, reti_pulse}, 32'd1);
    step();
    check("R9 one cycle", {31'd0, reti_pulse}, 32'd0);

    // R11 mode value 3 ignored, page load
    set_mode(2'd2);
    set_mode(2'd3);
    check("R11 mode 3 ignored", {30'd0, mode}, 32'd2);
    load_page(8'h9C);
    check("R11 page load", {24'd0, page}, 32'h9C);

    // R12 take beats enable strobe at same edge
    do_en();
    irq_n = 1'b0; en_stb = 1'b1;
    pulse_boundary();
    en_stb = 1'b0; irq_n = 1'b1;
    check("R12 take wins over enable", {30'd0, en_main, en_shadow}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule